// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This block sits beside the program-counter logic of a small processor and gives it loops with no software bookkeeping. The decode stage raises a start-of-loop strobe together with an iteration count and the current program counter. The block then remembers the address just past that instruction as the loop entry point, and it keeps a down-counter for the iterations.

At the end of the loop body, decode raises an end-of-loop strobe. In the same cycle the block says whether to jump back and gives the address to fetch next. When a loop runs out, the block drops it and the enclosing loop becomes current again. Loops can therefore nest up to a parameterised depth.

Misuse is reported on two single-cycle error outputs. One fires when a loop is started while every level is already occupied. The other fires when a loop is ended while none is open.

Top module: `nest_loop_ctrl`

## Requirements
- R1: With `rst_n` low at a rising clock edge, every level is cleared and no loop is open. An end-of-loop strobe issued right after reset gives `err_unf_o`=1 and `jump_o`=0.
- R2: A start strobe (`start_i`=1, `end_i`=0) with free space does two things at the next edge: it opens a new innermost loop with the count from `count_i`, and it records `pc_i`+1 as that loop's entry address.
- R3: A loop opened with count N≥1 runs its body N times. The first N−1 end strobes jump, and the N-th does not. Each jumping end strobe lowers the counter by one. A count of 0 behaves exactly like a count of 1.
- R4: An end strobe that does not jump gives `next_pc_o`=`pc_i`+1. It also closes the innermost loop at the next edge.
- R5: When an inner loop closes, the enclosing loop's remaining count and entry address become current again, unchanged. At most `DEPTH` loops (default 3) are open at once.
- R6: A start strobe while `DEPTH` loops are open gives `err_ovf_o`=1 in the same cycle and leaves every level and count unchanged.
- R7: An end strobe with no open loop gives `err_unf_o`=1 and `jump_o`=0 in the same cycle, and changes nothing.
- R8: `jump_o`, `next_pc_o` and the error flags are combinational in the strobe's cycle. A jumping end strobe gives `next_pc_o` equal to the innermost loop's entry address. Counter and level changes appear from the next rising edge.
- R9: When `start_i` and `end_i` are both high, only the start acts. The end strobe is ignored: `jump_o`=0, `err_unf_o`=0, and no count changes.
- R10: Addresses wrap modulo 2^`ADDR_W`, so the address after all-ones is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start-of-loop strobe from decode |
| end_i | input | 1 | End-of-loop strobe from decode |
| count_i | input | CNT_W | Iteration count for a start strobe |
| pc_i | input | ADDR_W | Address of the strobing instruction |
| jump_o | output | 1 | Branch back to the loop entry |
| next_pc_o | output | ADDR_W | Loop entry when jumping, else `pc_i`+1 |
| err_ovf_o | output | 1 | Start strobe refused, all levels occupied |
| err_unf_o | output | 1 | End strobe with no open loop |

## Verification
A corrupted counter shows up at the first end strobe that follows it, because the loop jumps too few or too many times. A corrupted entry address appears on `next_pc_o` the next time that loop jumps back. A wrong level count shows up one cycle after an inner loop closes, or only at the bottom of the stack, where an end strobe raises or misses the underflow flag. The bench therefore drains every loop it opens down to an underflow, so that a bad level count cannot stay hidden.

// File: rtl/nest_loop_pkg.sv
// Package: shared defaults for the nested loop controller.
// Assumes: all widths are at least 2 bits.
package nest_loop_pkg;
    localparam int DEF_ADDR_W = 16;
    localparam int DEF_CNT_W  = 16;
    localparam int DEF_DEPTH  = 3;
endpackage

// File: rtl/loop_level_stack.sv
// Module: loop_level_stack
// Holds one {count, entry address} pair per nesting level, plus a level
// counter. The innermost open level is presented on the top_* outputs.
// Assumes the caller never pushes when full or pops/decrements when empty.
module loop_level_stack #(
    parameter int DEPTH  = 3,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [CNT_W-1:0]  push_cnt_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              dec_i,
    input  logic              pop_i,
    output logic [CNT_W-1:0]  top_cnt_o,
    output logic [ADDR_W-1:0] top_addr_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [LVL_W-1:0]  lvl_q;
    logic [CNT_W-1:0]  cnt_q  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];

    assign empty_o = (lvl_q == '0);
    assign full_o  = (lvl_q == LVL_W'(DEPTH));

    // Level counter: one up on push, one down on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)      lvl_q <= '0;
        else if (push_i) lvl_q <= lvl_q + 1'b1;
        else if (pop_i)  lvl_q <= lvl_q - 1'b1;
    end

    // One storage slot per level: loaded on push into it, decremented while innermost.
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[k]  <= '0;
                addr_q[k] <= '0;
            end else if (push_i && lvl_q == LVL_W'(k)) begin
                cnt_q[k]  <= push_cnt_i;
                addr_q[k] <= push_addr_i;
            end else if (dec_i && lvl_q == LVL_W'(k + 1)) begin
                cnt_q[k]  <= cnt_q[k] - 1'b1;
            end
        end
    end

    // Select the innermost open slot for the decision logic.
    always_comb begin
        top_cnt_o  = '0;
        top_addr_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (lvl_q == LVL_W'(k + 1)) begin
                top_cnt_o  = cnt_q[k];
                top_addr_o = addr_q[k];
            end
        end
    end

    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> lvl_q == '0);
    assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= LVL_W'(DEPTH));
    assert_no_push_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && full_o));
    assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !((pop_i || dec_i) && empty_o));
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |=> top_cnt_o == $past(top_cnt_o) - 1'b1);
    assert_pop_restores_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> lvl_q == $past(lvl_q) - 1'b1);
endmodule

// File: rtl/loop_decide.sv
// Module: loop_decide
// Combinational strobe decoder: turns start/end strobes and the innermost
// level into jump, next address, error flags and stack commands.
// Assumes start has priority over end when both are raised.
module loop_decide #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16
) (
    input  logic              start_i,
    input  logic              end_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              empty_i,
    input  logic              full_i,
    input  logic [CNT_W-1:0]  top_cnt_i,
    input  logic [ADDR_W-1:0] top_addr_i,
    output logic              jump_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              err_ovf_o,
    output logic              err_unf_o,
    output logic              push_o,
    output logic [CNT_W-1:0]  push_cnt_o,
    output logic [ADDR_W-1:0] push_addr_o,
    output logic              dec_o,
    output logic              pop_o
);
    logic end_live;
    logic [ADDR_W-1:0] pc_next;

    // Derive every decision from the strobes and the innermost level.
    always_comb begin
        pc_next     = pc_i + 1'b1;
        end_live    = end_i && !start_i && !empty_i;
        err_ovf_o   = start_i && full_i;
        err_unf_o   = end_i && !start_i && empty_i;
        push_o      = start_i && !full_i;
        push_cnt_o  = (count_i == '0) ? CNT_W'(1) : count_i;
        push_addr_o = pc_next;
        jump_o      = end_live && (top_cnt_i > CNT_W'(1));
        dec_o       = jump_o;
        pop_o       = end_live && !jump_o;
        next_pc_o   = jump_o ? top_addr_i : pc_next;
    end
endmodule

// File: rtl/nest_loop_ctrl.sv
// Module: nest_loop_ctrl (top)
// Nested loop controller: a start strobe opens a loop recording pc+1 as
// entry, an end strobe jumps back until the count runs out, then closes it.
// Assumes at most one strobe instruction per cycle from decode.
module nest_loop_ctrl #(
    parameter int ADDR_W = nest_loop_pkg::DEF_ADDR_W,
    parameter int CNT_W  = nest_loop_pkg::DEF_CNT_W,
    parameter int DEPTH  = nest_loop_pkg::DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              end_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              jump_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              err_ovf_o,
    output logic              err_unf_o
);
    logic              push, dec, pop, empty, full;
    logic [CNT_W-1:0]  push_cnt, top_cnt;
    logic [ADDR_W-1:0] push_addr, top_addr;

    loop_decide #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) decide_i (
        .start_i(start_i), .end_i(end_i), .count_i(count_i), .pc_i(pc_i),
        .empty_i(empty), .full_i(full), .top_cnt_i(top_cnt), .top_addr_i(top_addr),
        .jump_o(jump_o), .next_pc_o(next_pc_o),
        .err_ovf_o(err_ovf_o), .err_unf_o(err_unf_o),
        .push_o(push), .push_cnt_o(push_cnt), .push_addr_o(push_addr),
        .dec_o(dec), .pop_o(pop)
    );

    loop_level_stack #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) stack_i (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .push_cnt_i(push_cnt), .push_addr_i(push_addr),
        .dec_i(dec), .pop_i(pop),
        .top_cnt_o(top_cnt), .top_addr_o(top_addr),
        .empty_o(empty), .full_o(full)
    );

    assert_jump_on_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |-> (end_i && !start_i));
    assert_ovf_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf_o |-> start_i);
    assert_no_jump_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(jump_o && err_unf_o));
    assert_both_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && end_i) |-> (!jump_o && !err_unf_o));
    assert_ovf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovf_o && !end_i) |=> $stable(top_addr) && $stable(top_cnt));
endmodule

// File: tb/nest_loop_ctrl_tb_top.sv
module nest_loop_ctrl_tb_top;
    localparam int AW = 16;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, end_i = 1'b0;
    logic [CW-1:0] count_i = '0;
    logic [AW-1:0] pc_i = '0;
    logic jump_o, err_ovf_o, err_unf_o;
    logic [AW-1:0] next_pc_o;

    int n_chk = 0;
    int n_fail = 0;
    logic s_jump, s_ovf, s_unf;
    logic [AW-1:0] s_next;

    always #5 clk = ~clk;

    nest_loop_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .end_i(end_i),
        .count_i(count_i), .pc_i(pc_i), .jump_o(jump_o), .next_pc_o(next_pc_o),
        .err_ovf_o(err_ovf_o), .err_unf_o(err_unf_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One instruction cycle: drive at negedge, sample before the next edge.
    task automatic step(input logic st, input logic en, input logic [CW-1:0] cnt,
                        input logic [AW-1:0] pc);
        @(negedge clk);
        start_i = st; end_i = en; count_i = cnt; pc_i = pc;
        #1;
        s_jump = jump_o; s_next = next_pc_o; s_ovf = err_ovf_o; s_unf = err_unf_o;
        @(negedge clk);
        start_i = 1'b0; end_i = 1'b0;
    endtask

    task automatic end_expect(input string tag, input logic [AW-1:0] pc,
                              input logic jmp, input logic [AW-1:0] nxt);
        step(1'b0, 1'b1, '0, pc);
        check({tag, " jump"}, 32'(s_jump), 32'(jmp));
        check({tag, " next"}, 32'(s_next), 32'(nxt));
        check({tag, " unf"}, 32'(s_unf), 32'd0);
    endtask

    task automatic expect_underflow(input string tag);
        step(1'b0, 1'b1, '0, 16'h0500);
        check({tag, " unf"}, 32'(s_unf), 32'd1);
        check({tag, " jump"}, 32'(s_jump), 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        expect_underflow("R1 reset empty");
    endtask

    task automatic t_single;
        step(1'b1, 1'b0, 16'd3, 16'd10);
        check("R2 start no ovf", 32'(s_ovf), 32'd0);
        end_expect("R2 R8 first end", 16'd12, 1'b1, 16'd11);
        end_expect("R3 second end", 16'd12, 1'b1, 16'd11);
        end_expect("R3 R4 last end", 16'd12, 1'b0, 16'd13);
        expect_underflow("R4 closed");
    endtask

    task automatic t_zero;
        step(1'b1, 1'b0, 16'd0, 16'd20);
        end_expect("R3 count0", 16'd21, 1'b0, 16'd22);
        expect_underflow("R3 count0 closed");
        step(1'b1, 1'b0, 16'd1, 16'd30);
        end_expect("R3 count1", 16'd31, 1'b0, 16'd32);
        expect_underflow("R3 count1 closed");
    endtask

    task automatic t_nest;
        step(1'b1, 1'b0, 16'd2, 16'd100);
        step(1'b1, 1'b0, 16'd3, 16'd101);
        end_expect("R5 inner a", 16'd103, 1'b1, 16'd102);
        end_expect("R5 inner b", 16'd103, 1'b1, 16'd102);
        end_expect("R5 inner done", 16'd103, 1'b0, 16'd104);
        end_expect("R5 outer restored", 16'd104, 1'b1, 16'd101);
        end_expect("R5 outer done", 16'd104, 1'b0, 16'd105);
        expect_underflow("R5 all closed");
    endtask

    task automatic t_overflow;
        step(1'b1, 1'b0, 16'd1, 16'd200);
        step(1'b1, 1'b0, 16'd1, 16'd201);
        step(1'b1, 1'b0, 16'd2, 16'd202);
        check("R5 third level accepted", 32'(s_ovf), 32'd0);
        step(1'b1, 1'b0, 16'd9, 16'd203);
        check("R6 ovf flag", 32'(s_ovf), 32'd1);
        end_expect("R6 top unchanged", 16'd210, 1'b1, 16'd203);
        end_expect("R6 top done", 16'd210, 1'b0, 16'd211);
        end_expect("R6 mid", 16'd211, 1'b0, 16'd212);
        end_expect("R6 outer", 16'd212, 1'b0, 16'd213);
        expect_underflow("R6 drained");
    endtask

    task automatic t_both;
        step(1'b1, 1'b1, 16'd2, 16'd300);
        check("R9 end ignored jump", 32'(s_jump), 32'd0);
        check("R9 end ignored unf", 32'(s_unf), 32'd0);
        end_expect("R9 start acted", 16'd302, 1'b1, 16'd301);
        end_expect("R9 done", 16'd302, 1'b0, 16'd303);
        expect_underflow("R9 drained");
    endtask

    task automatic t_wrap;
        step(1'b1, 1'b0, 16'd2, 16'hFFFF);
        end_expect("R10 wrap entry", 16'h0005, 1'b1, 16'h0000);
        end_expect("R10 wrap fall", 16'hFFFF, 1'b0, 16'h0000);
        expect_underflow("R10 drained");
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_zero();
        t_nest();
        t_overflow();
        t_both();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule